// File: doc/BRIEF.md
# Power-Good and Thermal Flag Logic

This block decides when a boost regulator may tell the rest of the system that its output supply is good. It combines the sequencer's soft-start completion and fault indications, a flag that says the switch current limit is active, and a digital die-temperature code. From these it drives the enable of an external open-drain pull-down on the power-good line, a thermal-shutdown request back to the sequencer, and a thermal-warning status.

The power-good line also serves as an early warning. It is pulled low when the current limit has stayed active for a qualified run of clock cycles, or when the die reaches a warning temperature. A separate, higher thermal threshold requests that the regulator stop. Each thermal level has its own hysteresis band, so a temperature hovering near a threshold does not make the outputs toggle.

The temperature code is an unsigned binary value of degrees Celsius (default 8 bits). With the default 1 MHz clock, the 64-cycle current-limit qualifier spans 64 µs. The sensor and the open-drain transistor are outside this block.

Top module: `pgood_thermal_flags`

## Requirements
- R1: During reset, and with `en` low, `pg_pd_en` is 1 and `therm_shdn` and `therm_warn` are 0.
- R2: Power-good is released (`pg_pd_en` = 0) on the first clock edge that samples `ss_done` high while `en` is high and no hold-off condition is present. The release persists after `ss_done` returns low.
- R3: When `ilim_act` has been sampled high on ILIM_CYC consecutive edges (default 64), `pg_pd_en` is 1 after that edge. After ILIM_CYC-1 such edges it is still 0.
- R4: A single edge that samples `ilim_act` low resets the qualifier to zero, so a second run must again reach a full ILIM_CYC edges before it trips.
- R5: The current-limit hold-off ends at the first edge that samples `ilim_act` low, and power-good is then released again without a new soft-start.
- R6: `therm_warn` becomes 1 after an edge that samples `temp_code` above WARN_SET (default 120). It stays 1 while the code is above WARN_CLR (default 100) and becomes 0 once the code is at or below WARN_CLR. A code equal to WARN_SET does not set it. While `therm_warn` is 1, `pg_pd_en` is 1.
- R7: `therm_shdn` becomes 1 after an edge that samples `temp_code` above SHDN_SET (default 150). It stays 1 down to SHDN_CLR+1 (default 131) and clears at or below SHDN_CLR (default 130). `therm_shdn` implies `therm_warn`, and `pg_pd_en` is 1 while it is set.
- R8: `fault` high drives `pg_pd_en` to 1 in the same cycle, without waiting for a clock edge. After a fault, power-good stays low until `ss_done` is sampled high again.
- R9: An edge that samples `en` low clears the thermal state and the soft-start record. After re-enabling at a temperature inside a hysteresis band, both thermal flags read 0, and power-good waits for a new `ss_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (1 MHz by default, sets qualifier time) |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Regulator enable; low clears all state |
| ss_done | input | 1 | Sequencer reports soft-start completed |
| fault | input | 1 | Sequencer reports a fault condition |
| ilim_act | input | 1 | Switch current limit currently active |
| temp_code | input | TEMP_W | Die temperature in degrees Celsius, unsigned |
| pg_pd_en | output | 1 | 1 turns on the open-drain pull-down (power not good) |
| therm_shdn | output | 1 | Thermal shutdown request |
| therm_warn | output | 1 | Thermal warning status |

## Verification
On every cycle, assertions check the following: the hysteresis comparators set above their upper level, hold inside the band and clear at or below the lower level; the qualifier never reports a trip in the cycle after the limit flag was low; shutdown never appears without the warning; and disabling clears both thermal flags. Only the bench scenarios can show the exact timing. These are the exact edge on which a 64-cycle run trips compared with 63, the restart of the count after a one-cycle gap, the need for a fresh soft-start after a fault or disable, and the pull-down response to a fault with no clock edge.

// File: rtl/pgt_pkg.sv
package pgt_pkg;

  // Reasons that can hold power-good low, gathered in one place
  typedef struct packed {
    logic no_ss;
    logic fault;
    logic ilim;
    logic warn;
    logic shdn;
  } pg_hold_t;

  // Next state of a two-level hysteresis flag
  function automatic logic hyst_next(input logic cur, input logic hot, input logic cool);
    if (hot)  return 1'b1;
    if (cool) return 1'b0;
    return cur;
  endfunction

  // Any reason active means the pull-down is on
  function automatic logic any_hold(input pg_hold_t h);
    return |h;
  endfunction

endpackage

// File: rtl/pgt_hyst_cmp.sv
module pgt_hyst_cmp #(
  parameter int W       = 8,
  parameter int SET_LVL = 120,
  parameter int CLR_LVL = 100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] code,
  output logic         state
);
  import pgt_pkg::*;

  localparam logic [W-1:0] SET_C = W'(SET_LVL);
  localparam logic [W-1:0] CLR_C = W'(CLR_LVL);

  logic hot, cool;
  assign hot  = code > SET_C;
  assign cool = code <= CLR_C;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) state <= 1'b0;
    else               state <= hyst_next(state, hot, cool);
  end

  AST_SET_ON_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && code > SET_C) |=> state); // R6, R7
  AST_HOLD_IN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state && code > CLR_C) |=> state); // R6, R7
  AST_CLEAR_ON_COOL: assert property (@(posedge clk) disable iff (!rst_n)
    (code <= CLR_C) |=> !state); // R6, R7

endmodule

// File: rtl/pgt_ilim_qual.sv
module pgt_ilim_qual #(
  parameter int RUN_LEN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic act,
  output logic trip
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] RUN_C = CW'(RUN_LEN);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !en || !act) run_cnt <= '0;
    else if (run_cnt != RUN_C)  run_cnt <= run_cnt + 1'b1;
  end

  assign trip = (run_cnt == RUN_C);

  AST_QUAL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> !trip); // R4
  AST_TRIP_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip) |-> $past(act)); // R3

endmodule

// File: rtl/pgood_thermal_flags.sv
module pgood_thermal_flags #(
  parameter int TEMP_W   = 8,
  parameter int WARN_SET = 120,
  parameter int WARN_CLR = 100,
  parameter int SHDN_SET = 150,
  parameter int SHDN_CLR = 130,
  parameter int ILIM_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ss_done,
  input  logic              fault,
  input  logic              ilim_act,
  input  logic [TEMP_W-1:0] temp_code,
  output logic              pg_pd_en,
  output logic              therm_shdn,
  output logic              therm_warn
);
  import pgt_pkg::*;

  logic     ss_ok;
  logic     ilim_trip;
  pg_hold_t hold;

  // Soft-start record: set by completion, dropped by any fault or disable
  always_ff @(posedge clk) begin
    if (!rst_n || !en || fault) ss_ok <= 1'b0;
    else if (ss_done)           ss_ok <= 1'b1;
  end

  pgt_hyst_cmp #(.W(TEMP_W), .SET_LVL(WARN_SET), .CLR_LVL(WARN_CLR)) u_warn (
    .clk(clk), .rst_n(rst_n), .en(en), .code(temp_code), .state(therm_warn));

  pgt_hyst_cmp #(.W(TEMP_W), .SET_LVL(SHDN_SET), .CLR_LVL(SHDN_CLR)) u_shdn (
    .clk(clk), .rst_n(rst_n), .en(en), .code(temp_code), .state(therm_shdn));

  pgt_ilim_qual #(.RUN_LEN(ILIM_CYC)) u_ilim (
    .clk(clk), .rst_n(rst_n), .en(en), .act(ilim_act), .trip(ilim_trip));

  always_comb begin
    hold.no_ss = !ss_ok || !en || !rst_n;
    hold.fault = fault;
    hold.ilim  = ilim_trip;
    hold.warn  = therm_warn;
    hold.shdn  = therm_shdn;
  end

  assign pg_pd_en = any_hold(hold);

  AST_SHDN_NEEDS_WARN: assert property (@(posedge clk) disable iff (!rst_n)
    therm_shdn |-> therm_warn); // R7
  AST_EN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!therm_shdn && !therm_warn)); // R9
  AST_PG_AFTER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !ss_done) |=> pg_pd_en); // R8

endmodule

// File: tb/test_pgood_thermal_flags.sv
module test_pgood_thermal_flags;
  localparam int CLK_PERIOD = 1000;
  localparam int ILIM = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0, en = 1'b0, ss_done = 1'b0, fault = 1'b0, ilim_act = 1'b0;
  logic [7:0] temp_code = 8'd25;
  logic pg_pd_en, therm_shdn, therm_warn;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgood_thermal_flags #(.ILIM_CYC(ILIM)) i_pgood_thermal_flags (
    .clk(clk), .rst_n(rst_n), .en(en), .ss_done(ss_done), .fault(fault),
    .ilim_act(ilim_act), .temp_code(temp_code), .pg_pd_en(pg_pd_en),
    .therm_shdn(therm_shdn), .therm_warn(therm_warn));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic chk(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", what, act, exp);
    end
  endtask

  task automatic t_reset;
    step(2);
    chk(pg_pd_en, 1'b1, "R1 pd in reset");
    chk(therm_shdn, 1'b0, "R1 shdn in reset");
    chk(therm_warn, 1'b0, "R1 warn in reset");
    rst_n = 1'b1; step(1);
    chk(pg_pd_en, 1'b1, "R1 pd with en low");
  endtask

  task automatic t_startup;
    en = 1'b1; step(2);
    chk(pg_pd_en, 1'b1, "R2 held before soft-start");
    ss_done = 1'b1; step(1);
    chk(pg_pd_en, 1'b0, "R2 released after ss_done");
    ss_done = 1'b0; step(3);
    chk(pg_pd_en, 1'b0, "R2 release persists");
  endtask

  task automatic t_ilim;
    ilim_act = 1'b1; step(ILIM - 1);
    chk(pg_pd_en, 1'b0, "R3 short run no trip");
    step(1);
    chk(pg_pd_en, 1'b1, "R3 full run trips");
    ilim_act = 1'b0; step(1);
    chk(pg_pd_en, 1'b0, "R5 released on drop");
  endtask

  task automatic t_restart;
    ilim_act = 1'b1; step(ILIM - 1);
    ilim_act = 1'b0; step(1);
    ilim_act = 1'b1; step(ILIM - 1);
    chk(pg_pd_en, 1'b0, "R4 count restarted after gap");
    step(1);
    chk(pg_pd_en, 1'b1, "R4 second full run trips");
    ilim_act = 1'b0; step(1);
    chk(pg_pd_en, 1'b0, "R5 released again");
  endtask

  task automatic t_warn;
    temp_code = 8'd120; step(1);
    chk(therm_warn, 1'b0, "R6 equal to set level");
    chk(pg_pd_en, 1'b0, "R6 pg at set level");
    temp_code = 8'd121; step(1);
    chk(therm_warn, 1'b1, "R6 above set level");
    chk(pg_pd_en, 1'b1, "R6 pg low on warning");
    temp_code = 8'd101; step(1);
    chk(therm_warn, 1'b1, "R6 held in band");
    temp_code = 8'd100; step(1);
    chk(therm_warn, 1'b0, "R6 cleared at release level");
    chk(pg_pd_en, 1'b0, "R6 pg re-released");
  endtask

  task automatic t_shdn;
    temp_code = 8'd150; step(1);
    chk(therm_shdn, 1'b0, "R7 equal to shutdown level");
    temp_code = 8'd151; step(1);
    chk(therm_shdn, 1'b1, "R7 above shutdown level");
    chk(therm_warn, 1'b1, "R7 warning with shutdown");
    chk(pg_pd_en, 1'b1, "R7 pg low on shutdown");
    temp_code = 8'd131; step(1);
    chk(therm_shdn, 1'b1, "R7 held in band");
    temp_code = 8'd130; step(1);
    chk(therm_shdn, 1'b0, "R7 cleared at restart level");
    chk(pg_pd_en, 1'b1, "R7 warning still holds pg");
    temp_code = 8'd25; step(1);
    chk(pg_pd_en, 1'b0, "R7 pg released when cool");
  endtask

  task automatic t_fault;
    fault = 1'b1; #(CLK_PERIOD/8);
    chk(pg_pd_en, 1'b1, "R8 immediate pull-down");
    step(1);
    fault = 1'b0; step(2);
    chk(pg_pd_en, 1'b1, "R8 waits for new soft-start");
    ss_done = 1'b1; step(1); ss_done = 1'b0;
    chk(pg_pd_en, 1'b0, "R8 released after new soft-start");
  endtask

  task automatic t_enable;
    temp_code = 8'd160; step(1);
    chk(therm_shdn, 1'b1, "R9 hot before disable");
    en = 1'b0; step(1);
    chk(therm_shdn, 1'b0, "R9 shdn cleared by disable");
    chk(therm_warn, 1'b0, "R9 warn cleared by disable");
    chk(pg_pd_en, 1'b1, "R1 pd with en low");
    temp_code = 8'd110; en = 1'b1; step(2);
    chk(therm_warn, 1'b0, "R9 warn stays clear in band");
    chk(therm_shdn, 1'b0, "R9 shdn stays clear");
    chk(pg_pd_en, 1'b1, "R9 needs new soft-start");
    ss_done = 1'b1; step(1); ss_done = 1'b0;
    chk(pg_pd_en, 1'b0, "R9 released after soft-start");
  endtask

  initial begin
    t_reset;
    t_startup;
    t_ilim;
    t_restart;
    t_warn;
    t_shdn;
    t_fault;
    t_enable;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual expired expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule